// File: doc/BRIEF.md
# Programmable Memory Strobe Line Driver

This block drives the fifth general-purpose strobe line of a memory controller, one copy for pin group A and one for pin group B. The controller has three engines that can own an access: a fixed-timing chip-select engine and two programmable engines, A and B. On every memory-engine cycle, the block decides which pin (if any) moves and what level it takes. It bases this on the owning engine, on whether the cycle is the first of a sequence, on two option bits and on two bits of the current microcode word.

The two clock phases are generated inside the block from the single system clock. One memory-engine cycle spans two system clocks. The first clock is the phase-1 slot, and its closing rising edge is the phase-1 update edge. The second clock is the phase-2 slot, closed by the phase-2 edge. `phase_o` shows which slot is current. The inputs must be held steady for both clocks of a cycle, and new cycle inputs are applied while `phase_o` is low.

For engine B, a routing bit sends the result to the group-A pin instead of the group-B pin. The level for the first cycle comes from an option bit. Each later cycle takes a separate microcode bit for each phase.

Top module: `strobe5_drv`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `line_a_o` and `line_b_o` are 1 and `phase_o` is 0.
- R2: `phase_o` toggles on every system clock edge after reset. A value of 0 marks the phase-1 slot and 1 marks the phase-2 slot.
- R3: When `owner_i` is 2'b00 (chip-select engine) or 2'b11 (no owner), neither pin changes at either phase edge.
- R4: With `owner_i`=2'b01 (engine A) and `first_i`=1, `line_a_o` takes `lvl_i` at the phase-1 edge and holds at the phase-2 edge.
- R5: With engine A and `first_i`=0, `line_a_o` takes `ucode_i[0]` at the phase-1 edge and `ucode_i[1]` at the phase-2 edge.
- R6: With engine A, `sel_i` has no effect and `line_b_o` never changes.
- R7: With `owner_i`=2'b10 (engine B) and `sel_i`=0, only `line_b_o` is driven and `line_a_o` holds.
- R8: With engine B and `sel_i`=1, only `line_a_o` is driven and `line_b_o` holds.
- R9: With engine B and `first_i`=1, the selected pin takes `lvl_i` at the phase-1 edge and holds at the phase-2 edge.
- R10: With engine B and `first_i`=0, the selected pin takes `ucode_i[0]` at the phase-1 edge and `ucode_i[1]` at the phase-2 edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| owner_i | input | 2 | Owning engine: 00 chip-select, 01 A, 10 B, 11 none |
| first_i | input | 1 | 1 in the first cycle of an engine sequence |
| sel_i | input | 1 | Engine B routing: 0 to group B pin, 1 to group A pin |
| lvl_i | input | 1 | Level used in the first cycle |
| ucode_i | input | 2 | Microcode bits: [0] phase-1 level, [1] phase-2 level |
| phase_o | output | 1 | Current phase slot: 0 phase 1, 1 phase 2 |
| line_a_o | output | 1 | Strobe line 5, group A |
| line_b_o | output | 1 | Strobe line 5, group B |

## Verification
The hardest case to reach is a pin holding a value that differs from its reset level while the other engine or the other route is active. Only that shows whether a pin that should hold has been written by mistake. The stimulus therefore mixes random cycles, which leave both pins at arbitrary levels, into an exhaustive sweep of every owner, cycle position, routing bit, level and microcode pair. This makes each hold check meet both prior levels. The phase-2 edge of a first cycle gets the same treatment. There, a phase-2 microcode bit that differs from the pin level must be seen to leave the pin unchanged.

// File: rtl/strobe5_drv.sv
module strobe5_drv #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] owner_i,
  input  logic       first_i,
  input  logic       sel_i,
  input  logic       lvl_i,
  input  logic [1:0] ucode_i,
  output logic       phase_o,
  output logic       line_a_o,
  output logic       line_b_o
);

  logic ph_q, a_q, b_q;
  logic eng_a, eng_b, act, val, to_a, to_b;

  assign eng_a = (owner_i == 2'b01);
  assign eng_b = (owner_i == 2'b10);
  assign act   = (eng_a | eng_b) & ~(ph_q & first_i);
  assign val   = ph_q ? ucode_i[1] : (first_i ? lvl_i : ucode_i[0]);
  assign to_a  = act & (eng_a | (eng_b & sel_i));
  assign to_b  = act & eng_b & ~sel_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= 1'b0;
      a_q  <= RESET_LEVEL;
      b_q  <= RESET_LEVEL;
    end else begin
      ph_q <= ~ph_q;
      if (to_a) a_q <= val;
      if (to_b) b_q <= val;
    end
  end

  assign phase_o  = ph_q;
  assign line_a_o = a_q;
  assign line_b_o = b_q;

endmodule

// File: rtl/strobe5_drv_chk.sv
module strobe5_drv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] owner_i,
  input logic       first_i,
  input logic       sel_i,
  input logic       lvl_i,
  input logic [1:0] ucode_i,
  input logic       phase_o,
  input logic       line_a_o,
  input logic       line_b_o
);

  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> phase_o != $past(phase_o)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i == 2'b00 || owner_i == 2'b11) |=> $stable(line_a_o) && $stable(line_b_o)); // R3
  AST_A_FIRST_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i == 2'b01 && first_i && !phase_o) |=> line_a_o == $past(lvl_i)); // R4
  AST_A_LATER_PH2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i == 2'b01 && !first_i && phase_o) |=> line_a_o == $past(ucode_i[1])); // R5
  AST_A_KEEPS_B: assert property (@(posedge clk) disable iff (!rst_n)
    owner_i == 2'b01 |=> $stable(line_b_o)); // R6
  AST_B_ROUTE_B: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i == 2'b10 && !sel_i) |=> $stable(line_a_o)); // R7
  AST_B_ROUTE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i == 2'b10 && sel_i) |=> $stable(line_b_o)); // R8
  AST_FIRST_PH2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (first_i && phase_o) |=> $stable(line_a_o) && $stable(line_b_o)); // R9
  AST_B_LATER_PH1: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_i == 2'b10 && !first_i && !phase_o && !sel_i) |=> line_b_o == $past(ucode_i[0])); // R10

endmodule

bind strobe5_drv strobe5_drv_chk u_chk (.*);

// File: tb/strobe5_drv_tb.sv
`timescale 1ns/1ps
module strobe5_drv_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] owner_i = 2'b00, ucode_i = 2'b00;
  logic first_i = 1'b0, sel_i = 1'b0, lvl_i = 1'b0;
  logic phase_o, line_a_o, line_b_o;
  int total = 0, bad = 0;
  logic ea, eb;
  bit done = 0;

  always #2.5 clk = ~clk;

  strobe5_drv dut_i (.*);

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic string tag_a(logic [1:0] o, logic f, logic s);
    if (o == 2'b01) return f ? "R4" : "R5";
    if (o == 2'b10) return s ? (f ? "R9" : "R10") : "R7";
    return "R3";
  endfunction

  function automatic string tag_b(logic [1:0] o, logic f, logic s);
    if (o == 2'b01) return "R6";
    if (o == 2'b10) return s ? "R8" : (f ? "R9" : "R10");
    return "R3";
  endfunction

  function automatic logic exp_val(logic ph2, logic f, logic l, logic [1:0] u);
    return ph2 ? u[1] : (f ? l : u[0]);
  endfunction

  task automatic model(logic ph2, logic [1:0] o, logic f, logic s, logic l, logic [1:0] u);
    if (ph2 && f) return;
    if (o == 2'b01 || (o == 2'b10 && s)) ea = exp_val(ph2, f, l, u);
    if (o == 2'b10 && !s) eb = exp_val(ph2, f, l, u);
  endtask

  task automatic cyc(logic [1:0] o, logic f, logic s, logic l, logic [1:0] u);
    owner_i = o; first_i = f; sel_i = s; lvl_i = l; ucode_i = u;
    @(posedge clk); #1;
    model(1'b0, o, f, s, l, u);
    chk("R2", phase_o, 1'b1);
    chk(tag_a(o, f, s), line_a_o, ea);
    chk(tag_b(o, f, s), line_b_o, eb);
    @(posedge clk); #1;
    model(1'b1, o, f, s, l, u);
    chk("R2", phase_o, 1'b0);
    chk(tag_a(o, f, s), line_a_o, ea);
    chk(tag_b(o, f, s), line_b_o, eb);
    @(negedge clk);
  endtask

  task automatic rnd_cyc();
    cyc(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
  endtask

  initial begin
    void'($urandom(32'd4242));
    ea = 1'b1; eb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", line_a_o, 1'b1);
    chk("R1", line_b_o, 1'b1);
    rst_n = 1'b1;
    #0.1;
    chk("R1", phase_o, 1'b0);
    // directed: first-cycle phase-2 hold with differing microcode (R4, R9)
    cyc(2'b01, 1'b1, 1'b0, 1'b0, 2'b10);
    cyc(2'b10, 1'b1, 1'b0, 1'b0, 2'b10);
    cyc(2'b10, 1'b1, 1'b1, 1'b1, 2'b00);
    // directed: engine A ignores sel (R6)
    cyc(2'b01, 1'b0, 1'b1, 1'b1, 2'b01);
    // directed: chip-select holds non-reset levels (R3)
    cyc(2'b00, 1'b0, 1'b0, 1'b1, 2'b11);
    for (int pass = 0; pass < 2; pass++)
      for (int o = 0; o < 4; o++)
        for (int f = 0; f < 2; f++)
          for (int s = 0; s < 2; s++)
            for (int l = 0; l < 2; l++)
              for (int u = 0; u < 4; u++) begin
                rnd_cyc();
                cyc(2'(o), 1'(f), 1'(s), 1'(l), 2'(u));
              end
    for (int i = 0; i < 600; i++) rnd_cyc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule